// File: doc/BRIEF.md
# Staggered DRAM Refresh Sequencer

This block produces the refresh command traffic for a DDR SDRAM controller that drives up to four chip selects. Interval ticks are collected in a saturating posted-refresh counter. While refresh work is owed, the block raises a request toward the controller's request arbiter. When the arbiter grants it, the block runs one refresh sequence:

- A precharge-all command goes out in three chip-select groups on back-to-back cycles.
- The block waits for the programmed precharge time.
- An auto-refresh command goes out in the same three groups, once for every posted tick.
- A recovery window follows each refresh pass and keeps all other traffic blocked.

Spreading the commands across three groups keeps the peak supply current down. The groups always run in full, whether or not every rank is fitted.

In sleep mode the block can put the memory into self-refresh. This happens only when the self-refresh enable is set. It precharges all ranks in staggered groups, then issues one refresh command to all chip selects at once with the clock enable dropped. The clock enable stays low until sleep is released. After that, the recovery window runs again before normal operation resumes. When the enable is clear, sleep mode provides no refresh at all and the block stays silent.

The arbiter handshake is a plain request/grant pair. A grant counts only in a cycle where the request is high. The request is never raised while the block is busy, so the arbiter sees no back-pressure from the block once a sequence has started.

Top module: `dram_rfsh_stagger`

## Requirements
- R1: Each cycle with `rfsh_tick` high adds one to the posted count, which saturates at 8. `rf_req` is high when idle with a non-zero count (outside sleep). `rf_urgent` is high when `rf_req` is high and the count equals 8.
- R2: The cycle after an accepted grant starts the precharge groups. The groups run on three consecutive cycles with `cmd_cs_n` equal to 4'b0110 (ranks 0 and 3), then 4'b1101 (rank 1), then 4'b1011 (rank 2). Precharge-all is encoded as {ras_n,cas_n,we_n} = 3'b010.
- R3: The first refresh group comes exactly max(3, `cfg_trp`) cycles after the first precharge group. No refresh is issued before all three precharge groups have gone out. Cycles in between are NOP, encoded 3'b111 with `cmd_cs_n` = 4'b1111.
- R4: Refresh uses the same three groups in the same order on consecutive cycles. Auto-refresh is encoded as {ras_n,cas_n,we_n} = 3'b001. All three groups are always issued.
- R5: After each refresh pass, M = max(`cfg_rec_base` + `cfg_rec_ext`, 1) NOP cycles follow. `busy` is high from the cycle after the grant through the last recovery cycle. `rf_req` is low whenever `busy` is high.
- R6: A grant captures the posted count P and runs P refresh passes, each followed by its recovery window. The precharge groups run only once per sequence. The count restarts from zero at the grant, plus one if a tick arrives in that same cycle. Ticks that arrive during the sequence are kept.
- R7: The configuration inputs are captured at the grant. Changing them during a sequence has no effect on that sequence.
- R8: With `sleep_req` and `self_rfsh_en` both high while idle, `rf_req` is high. The grant starts the staggered precharge groups and the wait of R3. A single cycle follows with `cmd_cs_n` = 4'b0000, code 3'b001 and `cmd_cke` low.
- R9: `cmd_cke` stays low with NOP commands while `sleep_req` stays high. The cycle after `sleep_req` is seen low, `cmd_cke` returns high. M recovery cycles with `busy` high follow, and then the block is idle. The posted count is zero on exit, including ticks that arrived during sleep.
- R10: With `sleep_req` high and `self_rfsh_en` low, `rf_req` and `rf_urgent` stay low, grants are ignored and no command is issued. Ticks are still counted and are requested after sleep ends.
- R11: During reset and when idle, `cmd_cs_n` = 4'b1111, the code is 3'b111, `cmd_cke` is high and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rfsh_tick | input | 1 | Refresh interval tick, one per interval |
| cfg_trp | input | TRP_W | Precharge-to-refresh spacing in cycles |
| cfg_rec_base | input | REC_W | Base recovery count |
| cfg_rec_ext | input | EXT_W | Extended recovery count, added to the base |
| sleep_req | input | 1 | Sleep mode requested |
| self_rfsh_en | input | 1 | Use self-refresh while in sleep |
| rf_req | output | 1 | Refresh or self-refresh entry wanted |
| rf_urgent | output | 1 | Posted count full, grant at once |
| rf_grant | input | 1 | Arbiter grant, taken only when rf_req is high |
| busy | output | 1 | Sequence or recovery in progress, other traffic blocked |
| cmd_cs_n | output | 4 | Active-low chip selects, bit i is rank i |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_cke | output | 1 | Clock enable |

## Verification
The bench aims at these corner cases:

- **Precharge spacing at or below three cycles.** Here the refresh groups must follow the precharge groups with no gap. A design that always inserted the wait would put a NOP cycle where a refresh belongs.
- **A recovery sum of zero.** A design that did not clamp it to one would leave recovery a cycle early.
- **A saturated count.** This must give exactly eight passes, with the urgent flag raised. An off-by-one counter would lose or add a whole pass.
- **Ticks during a sequence and during self-refresh.** The first kind must survive and the second must not.
- **Configuration changes mid-sequence.** These must not stretch the windows.
- **Sleep with self-refresh disabled.** This must not produce even one command.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  localparam int NUM_CS = 4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE0, ST_PRE1, ST_PRE2, ST_TRP,
    ST_REF0, ST_REF1, ST_REF2, ST_REC,
    ST_SRE,  ST_SLP,  ST_SRX
  } rf_state_e;

  // chip-select patterns per stagger group (bit i drives rank i)
  localparam logic [NUM_CS-1:0] GRP0_CSN = 4'b0110;
  localparam logic [NUM_CS-1:0] GRP1_CSN = 4'b1101;
  localparam logic [NUM_CS-1:0] GRP2_CSN = 4'b1011;

  // {ras_n, cas_n, we_n}
  localparam logic [2:0] CMD_NOP  = 3'b111;
  localparam logic [2:0] CMD_PREA = 3'b010;
  localparam logic [2:0] CMD_REF  = 3'b001;

endpackage

// File: rtl/rfsh_post_ctr.sv
module rfsh_post_ctr #(
  parameter int MAX = 8,
  parameter int PW  = $clog2(MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load_tick,
  input  logic          zero,
  output logic [PW-1:0] cnt,
  output logic          full
);

  localparam logic [PW-1:0] CMAX = PW'(MAX);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (zero)       cnt <= '0;
    else if (load_tick)  cnt <= tick ? PW'(1) : '0;
    else if (tick && cnt < CMAX) cnt <= cnt + PW'(1);
  end

  assign full = (cnt == CMAX);

  // R1: never beyond the saturation limit
  p_sat_limit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CMAX);

  // R1: a free tick below the limit adds exactly one
  p_tick_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_tick && !zero && cnt < CMAX) |=> cnt == $past(cnt) + PW'(1));

endmodule

// File: rtl/rfsh_cmd_enc.sv
module rfsh_cmd_enc
  import rfsh_pkg::*;
(
  input  rf_state_e         st,
  output logic [NUM_CS-1:0] cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              cke
);

  logic [2:0] code;

  always_comb begin
    cs_n = '1;
    code = CMD_NOP;
    cke  = 1'b1;
    unique case (st)
      ST_PRE0: begin cs_n = GRP0_CSN; code = CMD_PREA; end
      ST_PRE1: begin cs_n = GRP1_CSN; code = CMD_PREA; end
      ST_PRE2: begin cs_n = GRP2_CSN; code = CMD_PREA; end
      ST_REF0: begin cs_n = GRP0_CSN; code = CMD_REF;  end
      ST_REF1: begin cs_n = GRP1_CSN; code = CMD_REF;  end
      ST_REF2: begin cs_n = GRP2_CSN; code = CMD_REF;  end
      ST_SRE:  begin cs_n = '0; code = CMD_REF; cke = 1'b0; end
      ST_SLP:  cke = 1'b0;
      default: ;
    endcase
  end

  assign {ras_n, cas_n, we_n} = code;

endmodule

// File: rtl/dram_rfsh_stagger.sv
module dram_rfsh_stagger
  import rfsh_pkg::*;
#(
  parameter int PEND_MAX = 8,
  parameter int TRP_W    = 4,
  parameter int REC_W    = 6,
  parameter int EXT_W    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rfsh_tick,
  input  logic [TRP_W-1:0]   cfg_trp,
  input  logic [REC_W-1:0]   cfg_rec_base,
  input  logic [EXT_W-1:0]   cfg_rec_ext,
  input  logic               sleep_req,
  input  logic               self_rfsh_en,
  output logic               rf_req,
  output logic               rf_urgent,
  input  logic               rf_grant,
  output logic               busy,
  output logic [NUM_CS-1:0]  cmd_cs_n,
  output logic               cmd_ras_n,
  output logic               cmd_cas_n,
  output logic               cmd_we_n,
  output logic               cmd_cke
);

  localparam int PW   = $clog2(PEND_MAX + 1);
  localparam int SUMW = ((REC_W > EXT_W) ? REC_W : EXT_W) + 1;
  localparam int CW   = ((SUMW > TRP_W) ? SUMW : TRP_W) + 1;

  rf_state_e        st;
  logic [CW-1:0]    cnt, trp_q, rec_q;
  logic [PW-1:0]    pass_q, pend;
  logic             sr_q, pend_full;
  logic             sr_go, sleep_quiet, grant_ok, ctr_zero, ctr_load;
  logic [SUMW-1:0]  rec_sum;
  logic [CW-1:0]    rec_eff, cnt_nx;

  assign sr_go       = sleep_req && self_rfsh_en;
  assign sleep_quiet = sleep_req && !self_rfsh_en;
  assign rf_req      = (st == ST_IDLE) && !sleep_quiet && ((pend != '0) || sr_go);
  assign rf_urgent   = rf_req && pend_full;
  assign grant_ok    = rf_req && rf_grant;
  assign busy        = (st != ST_IDLE);

  assign rec_sum = SUMW'(cfg_rec_base) + SUMW'(cfg_rec_ext);
  assign rec_eff = (rec_sum == '0) ? CW'(1) : CW'(rec_sum);
  assign cnt_nx  = cnt + CW'(1);

  assign ctr_load = grant_ok && !sr_go;
  assign ctr_zero = (grant_ok && sr_go) || (busy && sr_q);

  rfsh_post_ctr #(.MAX(PEND_MAX), .PW(PW)) u_post (
    .clk(clk), .rst_n(rst_n), .tick(rfsh_tick),
    .load_tick(ctr_load), .zero(ctr_zero),
    .cnt(pend), .full(pend_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      trp_q  <= '0;
      rec_q  <= CW'(1);
      pass_q <= '0;
      sr_q   <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (grant_ok) begin
          st     <= ST_PRE0;
          cnt    <= '0;
          trp_q  <= CW'(cfg_trp);
          rec_q  <= rec_eff;
          sr_q   <= sr_go;
          pass_q <= pend;
        end
        ST_PRE0: begin st <= ST_PRE1; cnt <= cnt_nx; end
        ST_PRE1: begin st <= ST_PRE2; cnt <= cnt_nx; end
        ST_PRE2, ST_TRP: begin
          cnt <= cnt_nx;
          if (cnt_nx >= trp_q) st <= sr_q ? ST_SRE : ST_REF0;
          else                 st <= ST_TRP;
        end
        ST_REF0: st <= ST_REF1;
        ST_REF1: st <= ST_REF2;
        ST_REF2: begin
          st     <= ST_REC;
          cnt    <= '0;
          pass_q <= pass_q - PW'(1);
        end
        ST_REC: begin
          cnt <= cnt_nx;
          if (cnt_nx >= rec_q) st <= (pass_q != '0) ? ST_REF0 : ST_IDLE;
        end
        ST_SRE: st <= ST_SLP;
        ST_SLP: if (!sleep_req) begin st <= ST_SRX; cnt <= '0; end
        ST_SRX: begin
          cnt <= cnt_nx;
          if (cnt_nx >= rec_q) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  rfsh_cmd_enc u_enc (
    .st(st), .cs_n(cmd_cs_n), .ras_n(cmd_ras_n), .cas_n(cmd_cas_n),
    .we_n(cmd_we_n), .cke(cmd_cke)
  );

  // R5: no new request while a sequence or its recovery is running
  p_req_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_req |-> !busy);

  // R5: busy ends only out of a recovery window
  p_busy_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(st) == ST_REC || $past(st) == ST_SRX));

  // R3: the first refresh group only follows precharge or recovery
  p_ref_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REF0) |-> ($past(st) == ST_PRE2 || $past(st) == ST_TRP || $past(st) == ST_REC));

  // R2: outside self-refresh entry at most two ranks are selected at once
  p_stagger_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_SRE) |-> ($countones(cmd_cs_n) >= 2));

  // R9: clock enable is low only on entry and during sleep
  p_cke_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_cke |-> (st == ST_SRE || st == ST_SLP));

  // R10: sleep without self-refresh never starts a sequence
  p_quiet_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && sleep_quiet) |=> st == ST_IDLE);

endmodule

// File: tb/dram_rfsh_stagger_tb.sv
`timescale 1ns/1ps
module dram_rfsh_stagger_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rfsh_tick = 1'b0;
  logic [3:0] cfg_trp = '0;
  logic [5:0] cfg_rec_base = '0;
  logic [3:0] cfg_rec_ext = '0;
  logic       sleep_req = 1'b0;
  logic       self_rfsh_en = 1'b0;
  logic       rf_req, rf_urgent, busy;
  logic       rf_grant = 1'b0;
  logic [3:0] cmd_cs_n;
  logic       cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_cke;

  int n_chk = 0;
  int n_fail = 0;
  int pend_m = 0;
  int unsigned seed_v;

  always #5 clk = ~clk;

  dram_rfsh_stagger dut_i (
    .clk(clk), .rst_n(rst_n), .rfsh_tick(rfsh_tick), .cfg_trp(cfg_trp),
    .cfg_rec_base(cfg_rec_base), .cfg_rec_ext(cfg_rec_ext),
    .sleep_req(sleep_req), .self_rfsh_en(self_rfsh_en),
    .rf_req(rf_req), .rf_urgent(rf_urgent), .rf_grant(rf_grant), .busy(busy),
    .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
    .cmd_we_n(cmd_we_n), .cmd_cke(cmd_cke)
  );

  localparam logic [8:0] IDLE_W = {1'b0, 1'b1, 4'hF, 3'b111};

  function automatic logic [3:0] grp(int g);
    return (g == 0) ? 4'b0110 : (g == 1) ? 4'b1101 : 4'b1011;
  endfunction

  // expected {busy, cke, cs_n, ras_n, cas_n, we_n} at index i of a refresh sequence
  function automatic logic [8:0] exp_ref(int i, int r, int p, int m);
    int per = 3 + m;
    if (i < 3) return {1'b1, 1'b1, grp(i), 3'b010};
    if (i < r) return {1'b1, 1'b1, 4'hF, 3'b111};
    if (i - r < p * per) begin
      if ((i - r) % per < 3) return {1'b1, 1'b1, grp((i - r) % per), 3'b001};
      return {1'b1, 1'b1, 4'hF, 3'b111};
    end
    return IDLE_W;
  endfunction

  function automatic string tag_ref(int i, int r, int p, int m);
    if (i < 3) return "R2";
    if (i < r) return "R3";
    if (i - r >= p * (3 + m)) return "R5";
    if (i - r >= 3 + m) return "R6";
    if ((i - r) % (3 + m) < 3) return "R4";
    return "R5";
  endfunction

  function automatic logic [8:0] exp_sr(int i, int r, int d, int m);
    if (i < 3) return {1'b1, 1'b1, grp(i), 3'b010};
    if (i < r) return {1'b1, 1'b1, 4'hF, 3'b111};
    if (i == r) return {1'b1, 1'b0, 4'h0, 3'b001};
    if (i <= r + d) return {1'b1, 1'b0, 4'hF, 3'b111};
    if (i <= r + d + m) return {1'b1, 1'b1, 4'hF, 3'b111};
    return IDLE_W;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [8:0] obs();
    return {busy, cmd_cke, cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_ticks(int n);
    repeat (n) begin @(negedge clk); rfsh_tick = 1'b1; end
    @(negedge clk); rfsh_tick = 1'b0;
    pend_m = (pend_m + n > 8) ? 8 : pend_m + n;
  endtask

  task automatic do_seq(int trp, int base, int ext, bit tick_mid);
    int p, r, m, total;
    chk(rf_req == (pend_m != 0), "R1", "rf_req before grant", rf_req, pend_m != 0);
    chk(rf_urgent == (pend_m == 8), "R1", "rf_urgent", rf_urgent, pend_m == 8);
    cfg_trp = 4'(trp); cfg_rec_base = 6'(base); cfg_rec_ext = 4'(ext);
    rf_grant = 1'b1;
    @(negedge clk);
    rf_grant = 1'b0;
    p = pend_m; pend_m = 0;
    r = imax(3, trp); m = imax(base + ext, 1); total = r + p * (3 + m);
    // R7: scramble configuration after capture
    cfg_trp = 4'($urandom); cfg_rec_base = 6'($urandom); cfg_rec_ext = 4'($urandom);
    chk(rf_req == 1'b0, "R5", "rf_req while busy", rf_req, 0);
    for (int i = 0; i <= total; i++) begin
      chk(obs() == exp_ref(i, r, p, m), tag_ref(i, r, p, m), $sformatf("seq idx %0d", i),
          obs(), exp_ref(i, r, p, m));
      if (tick_mid && i == 1) begin rfsh_tick = 1'b1; pend_m = 1; end
      if (i == 2) rfsh_tick = 1'b0;
      @(negedge clk);
    end
    chk(rf_req == (pend_m != 0), "R6", "ticks kept across sequence", rf_req, pend_m != 0);
  endtask

  task automatic do_sleep(int trp, int base, int ext, int d);
    int r, m;
    cfg_trp = 4'(trp); cfg_rec_base = 6'(base); cfg_rec_ext = 4'(ext);
    sleep_req = 1'b1; self_rfsh_en = 1'b1;
    @(negedge clk);
    chk(rf_req == 1'b1, "R8", "rf_req for self-refresh", rf_req, 1);
    rf_grant = 1'b1;
    @(negedge clk);
    rf_grant = 1'b0;
    r = imax(3, trp); m = imax(base + ext, 1);
    for (int i = 0; i <= r + d + m + 1; i++) begin
      chk(obs() == exp_sr(i, r, d, m), (i <= r) ? "R8" : "R9", $sformatf("sleep idx %0d", i),
          obs(), exp_sr(i, r, d, m));
      if (i == r + 1) rfsh_tick = 1'b1;
      if (i == r + 2) rfsh_tick = 1'b0;
      if (i == r + d) sleep_req = 1'b0;
      @(negedge clk);
    end
    pend_m = 0;
    chk(rf_req == 1'b0, "R9", "count cleared after sleep", rf_req, 0);
    self_rfsh_en = 1'b0;
  endtask

  initial begin
    #(10ns * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    seed_v = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk(obs() == IDLE_W, "R11", "outputs in reset", obs(), IDLE_W);
    chk(rf_req == 1'b0, "R11", "rf_req in reset", rf_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(obs() == IDLE_W, "R11", "idle after reset", obs(), IDLE_W);

    // directed: short spacing, zero recovery sum, single tick
    pulse_ticks(1);
    do_seq(0, 0, 0, 1'b0);
    // directed: long spacing, recovery from both fields, tick during sequence
    pulse_ticks(2);
    do_seq(15, 5, 3, 1'b1);
    // directed: saturation -> eight passes
    pulse_ticks(10);
    do_seq(4, 1, 0, 1'b0);

    // R10: sleep without self-refresh stays silent, ticks counted
    sleep_req = 1'b1; self_rfsh_en = 1'b0;
    pulse_ticks(3);
    chk(rf_req == 1'b0, "R10", "rf_req in quiet sleep", rf_req, 0);
    chk(rf_urgent == 1'b0, "R10", "rf_urgent in quiet sleep", rf_urgent, 0);
    rf_grant = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(obs() == IDLE_W, "R10", "no command in quiet sleep", obs(), IDLE_W);
    end
    rf_grant = 1'b0; sleep_req = 1'b0;
    @(negedge clk);
    chk(rf_req == 1'b1, "R10", "ticks requested after sleep", rf_req, 1);
    do_seq(3, 2, 2, 1'b0);

    // self-refresh entry and exit
    do_sleep(2, 0, 0, 1);
    do_sleep(9, 4, 6, 5);

    // constrained random sequences
    for (int k = 0; k < 16; k++) begin
      pulse_ticks($urandom_range(1, 10));
      do_seq($urandom_range(0, 15), $urandom_range(0, 20), $urandom_range(0, 15),
             1'($urandom_range(0, 1)));
    end
    pulse_ticks(1);
    do_sleep($urandom_range(0, 15), $urandom_range(0, 10), $urandom_range(0, 5),
             $urandom_range(1, 6));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule